// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the time of day and the date as packed BCD digit pairs: seconds, minutes, hours, day of month, month and a two-digit year. Alongside them it keeps a three-bit weekday and a two-bit leap counter that selects which year is a leap year. A one-cycle `tick_1hz` pulse, taken from a 32.768 kHz oscillator divided down to 1 Hz, advances the seconds whenever `count_en` is high. Each carry ripples through minutes, hours, days, months and years. The month length follows the calendar, and February runs to 29 only when the leap counter is zero.

A host loads single digits through a write strobe with a digit index. All digits are driven out at all times, so a register read mux or an alarm comparator can use them directly. The `adj` input rounds the time to the nearest minute on its rising edge. One-cycle strobes mark every counted second and every minute advance.

Top module: `bcd_calendar`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs read 00:00:00, weekday 0, day 01, month 01, year 00, leap counter 0, and both strobes are low.
- R2: A `tick_1hz` pulse with `count_en` high adds one to the seconds in BCD and raises `sec_stb` for exactly one cycle. With `count_en` low, a tick changes nothing.
- R3: Seconds wrap from 59 to 00 and advance the minutes, and that minute advance raises `min_stb` for one cycle. Minutes wrap from 59 to 00 and advance the hours.
- R4: Hours wrap from 23 to 00. That wrap advances both the day of month and the weekday, and the weekday wraps from 6 to 0.
- R5: When the day reaches the month's length and is advanced, it becomes 01 and the month advances. The lengths are 30 days for months 04, 06, 09 and 11, the February rule of R6, and 31 days for every other month.
- R6: February has 29 days when the leap counter is 0 and 28 days otherwise.
- R7: Month 12 wraps to 01, which advances the year and adds one to the leap counter modulo 4. Year 99 wraps to 00.
- R8: On a rising edge of `adj` with no write in that cycle, seconds below 30 are cleared with no other change. Seconds of 30 or more are cleared and the minute advances with the full carry chain and `min_stb`. Holding `adj` high has no further effect, and a tick in the same cycle is dropped.
- R9: With `wr_en` high, `wr_data` is stored into the digit chosen by `wr_sel`, masked to that digit's width. The indices are: 0/1 seconds ones (4 bits) and tens (3 bits), 2/3 minutes ones (4) and tens (3), 4/5 hours ones (4) and tens (2), 6 weekday (3), 7/8 day ones (4) and tens (2), 9/10 month ones (4) and tens (1), 11/12 year ones and tens (4 each), 13 leap counter (2). Indices 14 and 15 change nothing.
- R10: A write takes priority over a tick or `adj` edge in the same cycle. The write is applied, the tick is dropped and `sec_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle 1 Hz advance pulse |
| count_en | input | 1 | Enables counting on ticks |
| adj | input | 1 | Round-to-minute request, acts on rising edge |
| wr_en | input | 1 | Digit write strobe |
| wr_sel | input | 4 | Digit index to write |
| wr_data | input | 4 | Digit value to write |
| sec_bcd | output | 8 | Seconds, tens:ones |
| min_bcd | output | 8 | Minutes, tens:ones |
| hour_bcd | output | 8 | Hours, tens:ones |
| day_bcd | output | 8 | Day of month, tens:ones |
| month_bcd | output | 8 | Month, tens:ones |
| year_bcd | output | 8 | Year, tens:ones |
| weekday | output | 3 | Day of week 0..6 |
| leap_cnt | output | 2 | Leap counter, 0 marks a leap year |
| sec_stb | output | 1 | Pulses after a counted second |
| min_stb | output | 1 | Pulses after a minute advance |

## Verification
Every result is due one clock after the edge that samples the stimulus. This holds for a written digit, a counted tick, an `adj` edge and the whole carry chain up to the year and leap counter, because the chain settles combinationally inside that one edge. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each check sees exactly the state after one rising edge. Strobes are read in that same cycle and again one cycle later to show they last a single clock.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       count_en,
  input  logic       adj,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [3:0] wr_data,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hour_bcd,
  output logic [7:0] day_bcd,
  output logic [7:0] month_bcd,
  output logic [7:0] year_bcd,
  output logic [2:0] weekday,
  output logic [1:0] leap_cnt,
  output logic       sec_stb,
  output logic       min_stb
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [1:0] lp);
    case (m)
      8'h02:                      return (lp == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic adj_q;
  wire adj_rise = adj & ~adj_q;
  wire tick_go  = tick_1hz & count_en & ~wr_en & ~adj_rise;
  wire sec_wrap = sec_bcd == 8'h59;
  wire c_min  = ~wr_en & ((tick_go & sec_wrap) | (adj_rise & (sec_bcd >= 8'h30)));
  wire c_hour = c_min  & (min_bcd == 8'h59);
  wire c_day  = c_hour & (hour_bcd == 8'h23);
  wire c_mon  = c_day  & (day_bcd >= month_len(month_bcd, leap_cnt));
  wire c_year = c_mon  & (month_bcd >= 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adj_q     <= 1'b0;
      sec_bcd   <= 8'h00;
      min_bcd   <= 8'h00;
      hour_bcd  <= 8'h00;
      day_bcd   <= 8'h01;
      month_bcd <= 8'h01;
      year_bcd  <= 8'h00;
      weekday   <= 3'd0;
      leap_cnt  <= 2'd0;
      sec_stb   <= 1'b0;
      min_stb   <= 1'b0;
    end else begin
      adj_q   <= adj;
      sec_stb <= tick_go;
      min_stb <= c_min;
      if (wr_en) begin
        case (wr_sel)
          4'd0:  sec_bcd[3:0]   <= wr_data;
          4'd1:  sec_bcd[7:4]   <= {1'b0, wr_data[2:0]};
          4'd2:  min_bcd[3:0]   <= wr_data;
          4'd3:  min_bcd[7:4]   <= {1'b0, wr_data[2:0]};
          4'd4:  hour_bcd[3:0]  <= wr_data;
          4'd5:  hour_bcd[7:4]  <= {2'b0, wr_data[1:0]};
          4'd6:  weekday        <= wr_data[2:0];
          4'd7:  day_bcd[3:0]   <= wr_data;
          4'd8:  day_bcd[7:4]   <= {2'b0, wr_data[1:0]};
          4'd9:  month_bcd[3:0] <= wr_data;
          4'd10: month_bcd[7:4] <= {3'b0, wr_data[0]};
          4'd11: year_bcd[3:0]  <= wr_data;
          4'd12: year_bcd[7:4]  <= wr_data;
          4'd13: leap_cnt       <= wr_data[1:0];
          default: ;
        endcase
      end else begin
        if (adj_rise)     sec_bcd <= 8'h00;
        else if (tick_go) sec_bcd <= sec_wrap ? 8'h00 : bcd_inc(sec_bcd);
        if (c_min)  min_bcd  <= (min_bcd == 8'h59) ? 8'h00 : bcd_inc(min_bcd);
        if (c_hour) hour_bcd <= (hour_bcd == 8'h23) ? 8'h00 : bcd_inc(hour_bcd);
        if (c_day) begin
          weekday <= (weekday >= 3'd6) ? 3'd0 : weekday + 3'd1;
          day_bcd <= (day_bcd >= month_len(month_bcd, leap_cnt)) ? 8'h01 : bcd_inc(day_bcd);
        end
        if (c_mon) month_bcd <= (month_bcd >= 8'h12) ? 8'h01 : bcd_inc(month_bcd);
        if (c_year) begin
          year_bcd <= (year_bcd == 8'h99) ? 8'h00 : bcd_inc(year_bcd);
          leap_cnt <= leap_cnt + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       count_en,
  input logic       adj,
  input logic       wr_en,
  input logic [7:0] sec_bcd,
  input logic [1:0] leap_cnt,
  input logic       sec_stb,
  input logic       min_stb
);

  p_stb_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_stb |-> $past(tick_1hz && count_en && !wr_en));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && count_en && !wr_en && !adj && sec_bcd == 8'h59) |=> (min_stb && sec_bcd == 8'h00));

  p_min_stb_zero_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_stb |-> sec_bcd == 8'h00);

  p_leap_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && leap_cnt != $past(leap_cnt)) |-> leap_cnt == $past(leap_cnt) + 2'd1);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !sec_stb);

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .count_en(count_en), .adj(adj),
  .wr_en(wr_en), .sec_bcd(sec_bcd), .leap_cnt(leap_cnt), .sec_stb(sec_stb), .min_stb(min_stb)
);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  logic clk = 0, rst_n = 0, tick_1hz = 0, count_en = 0, adj = 0, wr_en = 0;
  logic [3:0] wr_sel = 0, wr_data = 0;
  logic [7:0] sec_bcd, min_bcd, hour_bcd, day_bcd, month_bcd, year_bcd;
  logic [2:0] weekday;
  logic [1:0] leap_cnt;
  logic sec_stb, min_stb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_calendar u_dut (.*);

  // {sel, data, expected digit} for R9
  localparam logic [11:0] WR_VEC [16] = '{
    {4'd0, 4'hF, 4'hF}, {4'd1, 4'hF, 4'h7}, {4'd2, 4'hF, 4'hF}, {4'd3, 4'hF, 4'h7},
    {4'd4, 4'hF, 4'hF}, {4'd5, 4'hF, 4'h3}, {4'd6, 4'hF, 4'h7}, {4'd7, 4'hF, 4'hF},
    {4'd8, 4'hF, 4'h3}, {4'd9, 4'hF, 4'hF}, {4'd10, 4'hF, 4'h1}, {4'd11, 4'hF, 4'hF},
    {4'd12, 4'hF, 4'hF}, {4'd13, 4'hF, 4'h3}, {4'd5, 4'h6, 4'h2}, {4'd10, 4'h6, 4'h0}
  };

  function automatic logic [3:0] get_digit(input logic [3:0] s);
    case (s)
      4'd0: return sec_bcd[3:0];    4'd1: return sec_bcd[7:4];
      4'd2: return min_bcd[3:0];    4'd3: return min_bcd[7:4];
      4'd4: return hour_bcd[3:0];   4'd5: return hour_bcd[7:4];
      4'd6: return {1'b0, weekday};
      4'd7: return day_bcd[3:0];    4'd8: return day_bcd[7:4];
      4'd9: return month_bcd[3:0];  4'd10: return month_bcd[7:4];
      4'd11: return year_bcd[3:0];  4'd12: return year_bcd[7:4];
      4'd13: return {2'b0, leap_cnt};
      default: return 4'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] snap();
    return {sec_bcd, min_bcd, hour_bcd, day_bcd, month_bcd, year_bcd, 3'd0, weekday, 6'd0, leap_cnt};
  endfunction

  function automatic logic [63:0] mk(input logic [7:0] s, m, h, d, mo, y, input logic [2:0] w, input logic [1:0] l);
    return {s, m, h, d, mo, y, 3'd0, w, 6'd0, l};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] s, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, input logic [2:0] w, input logic [1:0] l);
    wr(0, s[3:0]);  wr(1, s[7:4]);  wr(2, m[3:0]);  wr(3, m[7:4]);
    wr(4, h[3:0]);  wr(5, h[7:4]);  wr(6, {1'b0, w}); wr(7, d[3:0]);
    wr(8, d[7:4]);  wr(9, mo[3:0]); wr(10, mo[7:4]); wr(11, y[3:0]);
    wr(12, y[7:4]); wr(13, {2'b0, l});
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset during", snap(), mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0, 2'd0));
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", snap(), mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0, 2'd0));
    check("R1 strobes", {sec_stb, min_stb}, 2'b00);

    // R9: digit write table
    for (int i = 0; i < 16; i++) begin
      wr(WR_VEC[i][11:8], WR_VEC[i][7:4]);
      check("R9 digit write", get_digit(WR_VEC[i][11:8]), WR_VEC[i][3:0]);
    end
    do_reset();
    wr(14, 4'h5); wr(15, 4'h5);
    check("R9 unused index", snap(), mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0, 2'd0));

    // R2: gated tick, then counted tick
    count_en = 0; tick();
    check("R2 tick gated off", {sec_bcd, sec_stb}, {8'h00, 1'b0});
    count_en = 1; tick();
    check("R2 counted tick", {sec_bcd, sec_stb}, {8'h01, 1'b1});
    @(negedge clk);
    check("R2 sec_stb one cycle", sec_stb, 1'b0);
    set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0, 2'd0);
    tick();
    check("R2 ones carry", sec_bcd, 8'h10);

    // R3: minute carry
    set_time(8'h59, 8'h14, 8'h07, 8'h05, 8'h03, 8'h20, 3'd2, 2'd1);
    tick();
    check("R3 sec wrap", snap(), mk(8'h00, 8'h15, 8'h07, 8'h05, 8'h03, 8'h20, 3'd2, 2'd1));
    check("R3 min_stb", min_stb, 1'b1);
    @(negedge clk);
    check("R3 min_stb one cycle", min_stb, 1'b0);

    // R4 R5: hour wrap, weekday 6->0, April 30 -> May 01
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h45, 3'd6, 2'd2);
    tick();
    check("R4 R5 day and weekday roll", snap(), mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h45, 3'd0, 2'd2));
    // R5: 31-day month does not roll at 30
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h07, 8'h45, 3'd3, 2'd2);
    tick();
    check("R5 July 30 to 31", snap(), mk(8'h00, 8'h00, 8'h00, 8'h31, 8'h07, 8'h45, 3'd4, 2'd2));

    // R6: February rule
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 3'd1, 2'd0);
    tick();
    check("R6 leap Feb 29", {day_bcd, month_bcd}, {8'h29, 8'h02});
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 3'd1, 2'd0);
    tick();
    check("R6 leap Feb 29 to Mar", {day_bcd, month_bcd}, {8'h01, 8'h03});
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h25, 3'd1, 2'd1);
    tick();
    check("R6 plain Feb 28 to Mar", {day_bcd, month_bcd}, {8'h01, 8'h03});

    // R7: year and leap counter
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 3'd5, 2'd3);
    tick();
    check("R7 century roll", snap(), mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd6, 2'd0));
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h19, 3'd0, 2'd1);
    tick();
    check("R7 year roll", {year_bcd, leap_cnt, month_bcd}, {8'h20, 2'd2, 8'h01});

    // R8: adj rounding
    set_time(8'h29, 8'h59, 8'h10, 8'h05, 8'h03, 8'h20, 3'd2, 2'd1);
    @(negedge clk); adj = 1;
    @(negedge clk);
    check("R8 adj below 30", snap(), mk(8'h00, 8'h59, 8'h10, 8'h05, 8'h03, 8'h20, 3'd2, 2'd1));
    check("R8 adj below 30 no min_stb", min_stb, 1'b0);
    @(negedge clk); adj = 0;
    set_time(8'h45, 8'h59, 8'h10, 8'h05, 8'h03, 8'h20, 3'd2, 2'd1);
    @(negedge clk); adj = 1; tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    check("R8 adj round up", snap(), mk(8'h00, 8'h00, 8'h11, 8'h05, 8'h03, 8'h20, 3'd2, 2'd1));
    check("R8 adj strobes", {min_stb, sec_stb}, 2'b10);
    wr(0, 4'h2); wr(1, 4'h4);
    @(negedge clk); @(negedge clk);
    check("R8 held adj ignored", {sec_bcd, min_bcd}, {8'h42, 8'h00});
    adj = 0;

    // R10: write beats tick
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0, 2'd0);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 4'h5; tick_1hz = 1;
    @(negedge clk); wr_en = 0; tick_1hz = 0;
    check("R10 write wins", {sec_bcd, sec_stb}, {8'h15, 1'b0});
    tick();
    check("R10 next tick counts", sec_bcd, 8'h16);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule